// File: doc/BRIEF.md
# Key-Sequence Machine-Cycle Watchdog

This block is a hardware watchdog for a small 8-bit controller. It watches the special-function-register write bus (address, data, write strobe) and counts machine cycles, which arrive as a one-clock strobe on the oscillator clock. After reset it is idle. Software turns it on by writing a two-byte key to one register address. Once it is on, software must keep writing that same key in time. If the key does not arrive in time, the block raises an active-high reset request of fixed length.

The key register is write-only and the block has no read path. The count cannot be loaded or observed, and no write turns the watchdog off. Only the hardware reset input, or the block's own overflow, returns it to the idle state. All ports are plain control and data pins. The block has no streaming interface, so no valid/ready back-pressure applies.

Top module: `seq_watchdog`

## Requirements
- R1: After the hardware reset input (`rst_ni` low) is released, `wdt_rst_o` is low and the block is idle. While idle it does not count, so no reset pulse is produced however many machine-cycle strobes arrive. Asserting `rst_ni` while the block is active also returns it to idle.
- R2: The block becomes active only when a write of 0x1E to address 0xA6 is followed by a write of 0xE1 to address 0xA6. The reverse order does not activate it.
- R3: Once active, the block cannot be turned off by any write to any address, whatever the data value.
- R4: While active, the count rises by one on each clock edge where `mc_tick_i` is high. Edges where `mc_tick_i` is low leave the count unchanged.
- R5: The count overflows on the 16383rd counted strobe after activation or after the last service. `wdt_rst_o` goes high on that same clock edge.
- R6: The clock edge that captures the 0xE1 key write clears the count to zero. A strobe on that edge is not counted.
- R7: After an overflow, `wdt_rst_o` stays high for exactly 98 clock periods and then falls.
- R8: An overflow makes the block idle. After the pulse no further pulse occurs until the block is activated again.
- R9: After 0x1E, a write to 0xA6 of any byte other than 0xE1 or 0x1E cancels the partial key. A later lone 0xE1 then does not service the block.
- R10: A write of 0x1E to 0xA6 always starts the key again, including directly after another 0x1E or after a cancelled attempt.
- R11: Writes to any address other than 0xA6 placed between the two key bytes neither advance nor cancel the key.
- R12: If a service (the 0xE1 key write) lands on the same clock edge as the overflowing strobe, the service wins: no pulse is issued and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous hardware reset, active low |
| mc_tick_i | input | 1 | Machine-cycle strobe, one clock wide |
| sfr_we_i | input | 1 | Register-bus write strobe |
| sfr_addr_i | input | 8 | Register-bus write address |
| sfr_wdata_i | input | 8 | Register-bus write data |
| wdt_rst_o | output | 1 | Reset request, active high, 98 clocks long |

## Verification
Two functions can fall on the same clock edge: a service, which clears the count, and the 16383rd strobe, which overflows it. The bench activates the block and keeps the strobe high on every clock. It then places the 0x1E byte on the edge before the predicted overflow edge and the 0xE1 byte exactly on that edge. The expected result is that no pulse appears at the old deadline and that the next pulse rises exactly 16383 strobes after the colliding write. A pulse at the old deadline shows up at the monitor as an unexpected pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // key tracker: waiting for the opening byte, or holding it
  typedef enum logic {
    KEY_WAIT_OPEN  = 1'b0,
    KEY_HAVE_OPEN  = 1'b1
  } key_state_e;

  localparam int unsigned SFR_AW_DEF   = 8;
  localparam int unsigned SFR_DW_DEF   = 8;
  localparam int unsigned WDT_CNT_DEF  = 14;
  localparam int unsigned WDT_HOLD_DEF = 98;

endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
#(
  parameter int unsigned         AW        = SFR_AW_DEF,
  parameter int unsigned         DW        = SFR_DW_DEF,
  parameter logic [AW-1:0]       KEY_ADDR  = 8'hA6,
  parameter logic [DW-1:0]       KEY_OPEN  = 8'h1E,
  parameter logic [DW-1:0]       KEY_CLOSE = 8'hE1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          key_ok_o
);

  key_state_e state_q, state_d;
  logic       hit;
  logic       is_open;
  logic       is_close;

  assign hit      = we_i && (addr_i == KEY_ADDR);
  assign is_open  = (data_i == KEY_OPEN);
  assign is_close = (data_i == KEY_CLOSE);

  // a complete key: closing byte while the opening byte is held
  assign key_ok_o = hit && is_close && (state_q == KEY_HAVE_OPEN);

  always_comb begin
    state_d = state_q;
    if (clr_i) begin
      state_d = KEY_WAIT_OPEN;
    end else if (hit) begin
      if ((state_q == KEY_HAVE_OPEN) && is_close) begin
        state_d = KEY_WAIT_OPEN;
      end else if (is_open) begin
        state_d = KEY_HAVE_OPEN;
      end else begin
        state_d = KEY_WAIT_OPEN;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= KEY_WAIT_OPEN;
    end else begin
      state_q <= state_d;
    end
  end

  AST_WRONG_BYTE_CANCELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !clr_i && !is_open) |=> (state_q == KEY_WAIT_OPEN)) else $error("cancel"); // R9

  AST_OPEN_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !clr_i && is_open && !key_ok_o) |=> (state_q == KEY_HAVE_OPEN)) else $error("restart"); // R10

  AST_FOREIGN_ADDR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i != KEY_ADDR) && !clr_i) |=> $stable(state_q)) else $error("foreign"); // R11

  AST_CLEAR_RESETS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (state_q == KEY_WAIT_OPEN)) else $error("clear"); // R8

endmodule

// File: rtl/wdt_mc_counter.sv
module wdt_mc_counter
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = WDT_CNT_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic key_ok_i,
  output logic ovf_o
);

  localparam logic [CNT_W-1:0] CNT_TOP  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_TOP - 1'b1;

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  // overflow: the strobe that would carry the count to its top value;
  // a service on the same edge takes priority
  assign ovf_o = armed_q && tick_i && !key_ok_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (key_ok_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (ovf_o) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (armed_q && tick_i) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  AST_IDLE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !key_ok_i) |=> (!armed_q && (cnt_q == '0))) else $error("idle"); // R1

  AST_NO_SW_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !ovf_o) |=> armed_q) else $error("disarm"); // R3

  AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && tick_i && !key_ok_i && !ovf_o) |=> (cnt_q == $past(cnt_q) + 1'b1)) else $error("step"); // R4

  AST_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !tick_i && !key_ok_i) |=> $stable(cnt_q)) else $error("hold"); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (cnt_q != CNT_TOP)) else $error("top"); // R5

  AST_SERVICE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_ok_i |=> (armed_q && (cnt_q == '0))) else $error("service"); // R6

  AST_OVF_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (!armed_q && (cnt_q == '0))) else $error("ovf"); // R8

endmodule

// File: rtl/wdt_rst_stretch.sv
module wdt_rst_stretch
  import wdt_pkg::*;
#(
  parameter int unsigned HOLD = WDT_HOLD_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic rst_o
);

  localparam int unsigned     PW       = $clog2(HOLD + 1);
  localparam logic [PW-1:0]   HOLD_VAL = PW'(HOLD);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
    end else if (fire_i) begin
      left_q <= HOLD_VAL;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign rst_o = (left_q != '0);

  AST_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> (rst_o && (left_q == HOLD_VAL))) else $error("start"); // R7

  AST_PULSE_COUNTDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((left_q != '0) && !fire_i) |=> (left_q == $past(left_q) - 1'b1)) else $error("countdown"); // R7

  AST_QUIET_WITHOUT_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_o && !fire_i) |=> !rst_o) else $error("quiet"); // R1

endmodule

// File: rtl/seq_watchdog.sv
module seq_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned            AW        = SFR_AW_DEF,
  parameter int unsigned            DW        = SFR_DW_DEF,
  parameter int unsigned            CNT_W     = WDT_CNT_DEF,
  parameter int unsigned            HOLD      = WDT_HOLD_DEF,
  parameter logic [AW-1:0]          KEY_ADDR  = 8'hA6,
  parameter logic [DW-1:0]          KEY_OPEN  = 8'h1E,
  parameter logic [DW-1:0]          KEY_CLOSE = 8'hE1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mc_tick_i,
  input  logic          sfr_we_i,
  input  logic [AW-1:0] sfr_addr_i,
  input  logic [DW-1:0] sfr_wdata_i,
  output logic          wdt_rst_o
);

  logic key_ok;
  logic ovf;

  wdt_key_seq #(
    .AW        (AW),
    .DW        (DW),
    .KEY_ADDR  (KEY_ADDR),
    .KEY_OPEN  (KEY_OPEN),
    .KEY_CLOSE (KEY_CLOSE)
  ) u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (ovf),
    .we_i     (sfr_we_i),
    .addr_i   (sfr_addr_i),
    .data_i   (sfr_wdata_i),
    .key_ok_o (key_ok)
  );

  wdt_mc_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (mc_tick_i),
    .key_ok_i (key_ok),
    .ovf_o    (ovf)
  );

  wdt_rst_stretch #(
    .HOLD (HOLD)
  ) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (ovf),
    .rst_o  (wdt_rst_o)
  );

  AST_SERVICE_BEATS_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_ok && !wdt_rst_o) |=> !wdt_rst_o) else $error("collision"); // R12

endmodule

// File: tb/test_seq_watchdog.sv
module test_seq_watchdog;

  localparam int LIM  = 16383;
  localparam int HOLD = 98;

  logic       clk   = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick  = 1'b1;
  logic       we    = 1'b0;
  logic [7:0] addr  = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic       wdt_rst;

  int    cyc     = 0;
  int    n_chk   = 0;
  int    n_bad   = 0;
  int    rises   = 0;
  int    rise_at = 0;
  int    e_cyc   = 0;
  string e_tag;
  logic  prev    = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  seq_watchdog i_seq_watchdog (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mc_tick_i   (tick),
    .sfr_we_i    (we),
    .sfr_addr_i  (addr),
    .sfr_wdata_i (wdata),
    .wdt_rst_o   (wdt_rst)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected pulse-start cycles and compares
  always @(negedge clk) begin
    if (wdt_rst && !prev) begin
      rises++;
      rise_at = cyc;
      if (exp_q.size() == 0) begin
        check(1'b0, "R3/R8 unexpected reset pulse", cyc, -1);
      end else begin
        e_cyc = exp_q.pop_front();
        e_tag = tag_q.pop_front();
        check(cyc == e_cyc, e_tag, cyc, e_cyc);
      end
    end
    if (!wdt_rst && prev) begin
      check((cyc - rise_at) == HOLD, "R7 pulse width", cyc - rise_at, HOLD);
    end
    prev = wdt_rst;
  end

  task automatic push(input int c, input string t);
    exp_q.push_back(c);
    tag_q.push_back(t);
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, output int e);
    @(negedge clk);
    addr  = a;
    wdata = d;
    we    = 1'b1;
    @(posedge clk);
    #1;
    e  = cyc;
    we = 1'b0;
  endtask

  task automatic arm(output int e);
    int x;
    wr(8'hA6, 8'h1E, x);
    wr(8'hA6, 8'hE1, e);
  endtask

  task automatic idle_check(input int len, input string t);
    int r0;
    r0 = rises;
    wait_cyc(cyc + len);
    check(rises == r0, t, rises - r0, 0);
  endtask

  initial begin
    int e;
    int s;
    int x;
    int t;
    repeat (3) @(negedge clk);
    check(wdt_rst == 1'b0, "R1 output low in reset", int'(wdt_rst), 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(wdt_rst == 1'b0, "R1 output low after reset", int'(wdt_rst), 0);
    wr(8'hA6, 8'hE1, x);
    idle_check(300, "R1 no counting while idle");

    // activation, strobe gap, overflow timing
    arm(e);
    push(e + LIM + 1000, "R2/R4/R5/R6 overflow timing with strobe gap");
    wait_cyc(e + 100);
    @(negedge clk);
    tick = 1'b0;
    repeat (1000) @(negedge clk);
    tick = 1'b1;
    wait_cyc(e + LIM + 1000 + HOLD + 4);
    wr(8'hA6, 8'hE1, x);
    wr(8'hA6, 8'h1E, x);
    idle_check(17000, "R8/R2 idle after pulse, reversed key ignored");

    // service colliding with the overflowing strobe
    arm(e);
    t = e + LIM;
    wait_cyc(t - 2);
    wr(8'hA6, 8'h1E, x);
    wr(8'hA6, 8'hE1, s);
    check(s == t, "R12 collision write placement", s, t);
    push(s + LIM, "R12 service wins over overflow");
    wait_cyc(s + LIM + HOLD + 4);

    // no software disarm, cancelled key does not service
    arm(e);
    push(e + LIM, "R3/R9 cancelled key and stray writes");
    wait_cyc(e + 500);
    wr(8'hA6, 8'h1E, x);
    wr(8'hA6, 8'h55, x);
    wr(8'hA6, 8'hE1, x);
    wr(8'hA6, 8'h00, x);
    wr(8'hA6, 8'hFF, x);
    wait_cyc(e + LIM + HOLD + 4);

    // foreign addresses between key bytes
    arm(e);
    wait_cyc(e + 500);
    wr(8'hA6, 8'h1E, x);
    wr(8'h80, 8'h5A, x);
    wr(8'hA5, 8'hE1, x);
    wr(8'hA6, 8'hE1, s);
    push(s + LIM, "R11 foreign writes keep key");
    wait_cyc(s + LIM + HOLD + 4);

    // restart of key by a fresh opening byte
    arm(e);
    wait_cyc(e + 500);
    wr(8'hA6, 8'h1E, x);
    wr(8'hA6, 8'h1E, x);
    wr(8'hA6, 8'hE1, s);
    wait_cyc(s + 300);
    wr(8'hA6, 8'h1E, x);
    wr(8'hA6, 8'h55, x);
    wr(8'hA6, 8'h1E, x);
    wr(8'hA6, 8'hE1, s);
    push(s + LIM, "R10 fresh opening byte restarts key");
    wait_cyc(s + LIM + HOLD + 4);

    // hardware reset returns to idle
    arm(e);
    wait_cyc(e + 200);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_check(17000, "R1 hardware reset disarms");

    check(exp_q.size() == 0, "R5 all expected pulses seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule